// File: doc/BRIEF.md
# Prioritized Edge-Triggered Interrupt Controller

The controller gathers sixteen edge-triggered interrupt sources and one bypass interrupt onto a single interrupt-priority output. It watches each source for a rising edge and latches it as pending in an active-low status register, where a pending source reads as 0. It then compares the source's programmable 3-bit level against a mask threshold. A source whose level is strictly greater than the entire mask word is forwarded as a one-cycle `ip_valid_o` pulse. The pulse carries a 6-bit code equal to 16 plus the source number. A rising edge on the bypass input always produces code 32. It does not touch the status register and ignores the mask.

Software reaches the status, mask and four level registers through a simple word-indexed register port with per-byte enables. When several qualifying edges land in one cycle, they are sent out lowest source first, one per cycle. A synchronous reset input returns the block to its power-on state.

The source bits are wired as follows. Bits 0..6 are external inputs 1..7, bits 7..10 are DMA channels 3, 2, 1, 0, bits 11..12 are serial channels 0 and 1, and bits 13..15 are timers 0, 1 and 2.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x0000FFFF, the mask register reads 0, all four level registers read 0, and `ip_valid_o` is 0.
- R2: Register word index 0 (byte offset 0x00) is status, index 1 (0x04) is mask, and indices 4..7 (0x10..0x1C) are the level registers for sources 0-3, 4-7, 8-11 and 12-15. Indices 2 and 3 read as 0, and writes to them change nothing.
- R3: A write updates only the byte lanes whose `reg_be_i` bit is set. Read data lanes whose `reg_be_i` bit is clear return 0.
- R4: A rising edge on source s clears status bit s, whether or not that source is forwarded. An input that is held high does not trigger again.
- R5: The level of source s is bits [(s%4)*8+2 : (s%4)*8] of level register s/4. The other bits of the register take no part. The source is forwarded only when this level, zero-extended, is strictly greater than the full 32-bit mask. It then shows as `ip_valid_o`=1 with `ip_code_o`=16+s, in the cycle after the edge is sampled.
- R6: A rising edge on `byp_i` emits code 32 in the cycle after it is sampled, whatever the mask holds, and it leaves the status register unchanged.
- R7: Qualifying edges in the same cycle are emitted one per cycle, lowest source first. A bypass edge in that cycle goes out before all of them.
- R8: Software writes can set or clear status bits. When a software write and a hardware edge hit the same status bit in one cycle, the bit ends up cleared.
- R9: `soft_rst_i` high at a clock edge restores the R1 register state, drops any queued emissions and forces `ip_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous reset to power-on state |
| src_i | input | 16 | Edge-triggered interrupt sources 0..15 |
| byp_i | input | 1 | Bypass interrupt, always code 32 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_word_i | input | 3 | Register word index (byte offset / 4) |
| reg_be_i | input | 4 | Byte lane enables for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| ip_valid_o | output | 1 | One-cycle interrupt event pulse |
| ip_code_o | output | 6 | Interrupt code: 16+s or 32 |

## Verification
A register write takes effect at the clock edge that samples it. Its read-back is combinational, so the bench drives reads at a falling edge and samples them shortly afterwards. A source or bypass edge is sampled at one rising edge, and its event shows on `ip_valid_o`/`ip_code_o` right after that same edge. The bench checks the event at the next falling edge, and each further queued emission one falling edge later. The hardware status clear is due at that same rising edge, so the bench reads the status back at the following falling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned N_SRC     = 16;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BYTES     = DATA_W / 8;
  localparam int unsigned SRC_PER_W = 4;
  localparam int unsigned N_LVL_REG = N_SRC / SRC_PER_W;
  localparam int unsigned WORD_W    = 3;
  localparam int unsigned CODE_BASE = 16;
  localparam int unsigned CODE_BYP  = 32;

  localparam logic [WORD_W-1:0] W_STATUS = 3'd0;
  localparam logic [WORD_W-1:0] W_MASK   = 3'd1;
  localparam logic [WORD_W-1:0] W_LVL0   = 3'd4;

  localparam logic [DATA_W-1:0] STATUS_RST = DATA_W'((64'd1 << N_SRC) - 64'd1);

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lvl_q <= '0;
    else if (soft_rst_i) lvl_q <= '0;
    else                 lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import prio_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    soft_rst_i,
  input  logic [N_SRC-1:0]        hw_clr_i,
  input  logic                    wr_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic [BYTES-1:0]        be_i,
  input  word_t                   wdata_i,
  output word_t                   rdata_o,
  output word_t                   mask_o,
  output word_t [N_LVL_REG-1:0]   lvl_o
);
  word_t status_q, mask_q;
  word_t [N_LVL_REG-1:0] lvl_q;

  function automatic word_t merge(word_t cur, word_t nw, logic [BYTES-1:0] be);
    word_t r = cur;
    for (int b = 0; b < BYTES; b++)
      if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  logic wr_status, wr_mask;
  assign wr_status = wr_i && (word_i == W_STATUS);
  assign wr_mask   = wr_i && (word_i == W_MASK);

  word_t status_sw;
  assign status_sw = wr_status ? merge(status_q, wdata_i, be_i) : status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
      mask_q   <= '0;
    end else if (soft_rst_i) begin
      status_q <= STATUS_RST;
      mask_q   <= '0;
    end else begin
      // hardware clear overrides a same-cycle software set
      status_q <= status_sw & ~DATA_W'(hw_clr_i);
      if (wr_mask) mask_q <= merge(mask_q, wdata_i, be_i);
    end
  end

  for (genvar g = 0; g < N_LVL_REG; g++) begin : g_lvl
    logic wr_lvl;
    assign wr_lvl = wr_i && (word_i == W_LVL0 + WORD_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         lvl_q[g] <= '0;
      else if (soft_rst_i) lvl_q[g] <= '0;
      else if (wr_lvl)     lvl_q[g] <= merge(lvl_q[g], wdata_i, be_i);
    end
  end

  word_t rd_word;
  always_comb begin
    rd_word = '0;
    if (word_i == W_STATUS)    rd_word = status_q;
    else if (word_i == W_MASK) rd_word = mask_q;
    else if (word_i >= W_LVL0) rd_word = lvl_q[word_i - W_LVL0];
    for (int b = 0; b < BYTES; b++)
      if (!be_i[b]) rd_word[b*8 +: 8] = 8'h00;
  end

  assign rdata_o = rd_word;
  assign mask_o  = mask_q;
  assign lvl_o   = lvl_q;

  AST_HW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_clr_i && !soft_rst_i) |=> ((status_q[N_SRC-1:0] & $past(hw_clr_i)) == '0)); // R4
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_q == STATUS_RST && mask_q == '0 && lvl_q == '0)); // R9
endmodule

// File: rtl/irq_emit_arb.sv
module irq_emit_arb
  import prio_irq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic [N_SRC-1:0]      rise_i,
  input  logic                  byp_rise_i,
  input  word_t                 mask_i,
  input  word_t [N_LVL_REG-1:0] lvl_i,
  output logic                  ip_valid_o,
  output logic [CODE_W-1:0]     ip_code_o
);
  logic [N_SRC-1:0] qual, pend_q, pend_d, cand;

  for (genvar s = 0; s < N_SRC; s++) begin : g_qual
    logic [LVL_W-1:0] lvl;
    assign lvl     = lvl_i[s / SRC_PER_W][(s % SRC_PER_W) * 8 +: LVL_W];
    assign qual[s] = rise_i[s] && (DATA_W'(lvl) > mask_i);
  end

  assign cand = pend_q | qual;

  logic                 emit_d;
  logic [CODE_W-1:0]    code_d;
  always_comb begin
    int unsigned idx;
    idx    = 0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (cand[i]) idx = i;
    emit_d = 1'b0;
    code_d = '0;
    pend_d = cand;
    if (byp_rise_i) begin
      emit_d = 1'b1;
      code_d = CODE_W'(CODE_BYP);
    end else if (|cand) begin
      emit_d      = 1'b1;
      code_d      = CODE_W'(CODE_BASE + idx);
      pend_d[idx] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      ip_valid_o <= 1'b0;
      ip_code_o  <= '0;
    end else if (soft_rst_i) begin
      pend_q     <= '0;
      ip_valid_o <= 1'b0;
      ip_code_o  <= '0;
    end else begin
      pend_q     <= pend_d;
      ip_valid_o <= emit_d;
      ip_code_o  <= code_d;
    end
  end

  AST_BYP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    byp_rise_i |=> (ip_valid_o && ip_code_o == CODE_W'(CODE_BYP))); // R6
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_valid_o |-> (ip_code_o == CODE_W'(CODE_BYP) || ip_code_o[CODE_W-1:4] == 2'b01)); // R5
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (|pend_q && !byp_rise_i) |=> (ip_valid_o && ip_code_o != CODE_W'(CODE_BYP))); // R7
  AST_QUIET_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !ip_valid_o); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              byp_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_word_i,
  input  logic [BYTES-1:0]  reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ip_valid_o,
  output logic [CODE_W-1:0] ip_code_o
);
  logic [N_SRC:0]        rise;
  word_t                 mask;
  word_t [N_LVL_REG-1:0] lvl;

  irq_edge_detect #(.W(N_SRC + 1)) i_edge (
    .clk_i, .rst_ni, .soft_rst_i,
    .lvl_i  ({byp_i, src_i}),
    .rise_o (rise)
  );

  irq_regbank i_regs (
    .clk_i, .rst_ni, .soft_rst_i,
    .hw_clr_i (rise[N_SRC-1:0]),
    .wr_i     (reg_wr_i),
    .word_i   (reg_word_i),
    .be_i     (reg_be_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .mask_o   (mask),
    .lvl_o    (lvl)
  );

  irq_emit_arb i_arb (
    .clk_i, .rst_ni, .soft_rst_i,
    .rise_i     (rise[N_SRC-1:0]),
    .byp_rise_i (rise[N_SRC]),
    .mask_i     (mask),
    .lvl_i      (lvl),
    .ip_valid_o,
    .ip_code_o
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [15:0] src = '0;
  logic        byp = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  word = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ip_valid;
  logic [5:0]  ip_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .src_i(src), .byp_i(byp),
    .reg_wr_i(wr), .reg_word_i(word), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ip_valid_o(ip_valid), .ip_code_o(ip_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] w, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; word = w; be = b; wdata = d;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic rreg(logic [2:0] w, logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    word = w; be = b;
    #1 d = rdata;
  endtask

  // drive inputs at a falling edge, let one rising edge sample them, return at next falling edge
  task automatic strike(logic [15:0] s, logic b);
    @(negedge clk);
    src = s; byp = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic evt(string req, logic v, logic [5:0] c);
    check({req, " valid"}, 32'(ip_valid), 32'(v));
    if (v) check({req, " code"}, 32'(ip_code), 32'(c));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rreg(3'd0, 4'hF, d); check("R1 status", d, 32'h0000FFFF);
    rreg(3'd1, 4'hF, d); check("R1 mask", d, 32'h0);
    for (int w = 4; w < 8; w++) begin
      rreg(3'(w), 4'hF, d); check("R1 level", d, 32'h0);
    end
    check("R1 valid", 32'(ip_valid), 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wreg(3'd5, 4'hF, 32'h01020304);
    rreg(3'd5, 4'hF, d); check("R2 level word5", d, 32'h01020304);
    rreg(3'd4, 4'hF, d); check("R2 level word4 untouched", d, 32'h0);
    wreg(3'd2, 4'hF, 32'hDEADBEEF);
    rreg(3'd2, 4'hF, d); check("R2 hole word2", d, 32'h0);
    wreg(3'd3, 4'hF, 32'h12345678);
    rreg(3'd3, 4'hF, d); check("R2 hole word3", d, 32'h0);
    rreg(3'd0, 4'hF, d); check("R2 status after hole writes", d, 32'h0000FFFF);
    rreg(3'd1, 4'hF, d); check("R2 mask after hole writes", d, 32'h0);
    wreg(3'd5, 4'hF, 32'h0);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    wreg(3'd1, 4'b0010, 32'hAABBCCDD);
    rreg(3'd1, 4'hF, d);    check("R3 one lane write", d, 32'h0000CC00);
    rreg(3'd1, 4'b0010, d); check("R3 lane read", d, 32'h0000CC00);
    rreg(3'd1, 4'b0001, d); check("R3 masked lane read", d, 32'h0);
    wreg(3'd1, 4'b1001, 32'h11223344);
    rreg(3'd1, 4'hF, d);    check("R3 two lane write", d, 32'h1100CC44);
    wreg(3'd1, 4'hF, 32'h0);
  endtask

  task automatic t_forward();
    logic [31:0] d;
    wreg(3'd5, 4'b0010, 32'h00000300); // source 5 level 3
    wreg(3'd1, 4'hF, 32'd2);
    strike(16'h0020, 1'b0); evt("R5 level3>mask2", 1'b1, 6'd21);
    rreg(3'd0, 4'hF, d); check("R4 status clear src5", d, 32'h0000FFDF);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    strike(16'h0000, 1'b0);
    wreg(3'd1, 4'hF, 32'd3);
    strike(16'h0020, 1'b0); evt("R5 level3 not > mask3", 1'b0, 6'd0);
    rreg(3'd0, 4'hF, d); check("R4 clear without forward", d, 32'h0000FFDF);
    wreg(3'd0, 4'hF, 32'h0000FFFF); // src5 still high
    idle(2);
    check("R4 held high no retrigger valid", 32'(ip_valid), 32'h0);
    rreg(3'd0, 4'hF, d); check("R4 held high status", d, 32'h0000FFFF);
    strike(16'h0000, 1'b0);
    wreg(3'd5, 4'b0010, 32'h0000F800); // field 0, upper bits set
    wreg(3'd1, 4'hF, 32'd0);
    strike(16'h0020, 1'b0); evt("R5 upper bits ignored", 1'b0, 6'd0);
    strike(16'h0000, 1'b0);
    wreg(3'd5, 4'b0010, 32'h0000FF00); // level 7
    wreg(3'd1, 4'hF, 32'h00000100);
    strike(16'h0020, 1'b0); evt("R5 full mask compare", 1'b0, 6'd0);
    strike(16'h0000, 1'b0);
    wreg(3'd1, 4'hF, 32'd6);
    strike(16'h0020, 1'b0); evt("R5 level7>mask6", 1'b1, 6'd21);
    strike(16'h0000, 1'b0); evt("R5 single-cycle pulse", 1'b0, 6'd0);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    wreg(3'd1, 4'hF, 32'hFFFFFFFF);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    strike(16'h0000, 1'b1); evt("R6 bypass code", 1'b1, 6'd32);
    strike(16'h0000, 1'b0); evt("R6 bypass one pulse", 1'b0, 6'd0);
    rreg(3'd0, 4'hF, d); check("R6 status untouched", d, 32'h0000FFFF);
    wreg(3'd1, 4'hF, 32'h0);
  endtask

  task automatic t_multi();
    for (int w = 4; w < 8; w++) wreg(3'(w), 4'hF, 32'h01010101);
    idle(1);
    strike(16'h4208, 1'b1); evt("R7 bypass first", 1'b1, 6'd32);
    src = '0; byp = 1'b0;
    @(negedge clk); evt("R7 second src3", 1'b1, 6'd19);
    @(negedge clk); evt("R7 third src9", 1'b1, 6'd25);
    @(negedge clk); evt("R7 fourth src14", 1'b1, 6'd30);
    @(negedge clk); evt("R7 drained", 1'b0, 6'd0);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
  endtask

  task automatic t_hwwins();
    logic [31:0] d;
    wreg(3'd0, 4'b0001, 32'h00000000);
    rreg(3'd0, 4'hF, d); check("R8 software clear", d, 32'h0000FF00);
    @(negedge clk);
    wr = 1'b1; word = 3'd0; be = 4'b0011; wdata = 32'h0000FFFF; src = 16'h0004;
    @(negedge clk);
    wr = 1'b0; be = '0; src = '0;
    rreg(3'd0, 4'hF, d); check("R8 hw clear beats sw set", d, 32'h0000FFFB);
    idle(3);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    wreg(3'd1, 4'hF, 32'h0);
    strike(16'h0007, 1'b0); evt("R9 first of queue", 1'b1, 6'd16);
    src = '0; soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    evt("R9 output dropped", 1'b0, 6'd0);
    @(negedge clk); evt("R9 queue dropped", 1'b0, 6'd0);
    rreg(3'd0, 4'hF, d); check("R9 status", d, 32'h0000FFFF);
    rreg(3'd1, 4'hF, d); check("R9 mask", d, 32'h0);
    rreg(3'd6, 4'hF, d); check("R9 level", d, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_bytes();
    t_forward();
    t_bypass();
    t_multi();
    t_hwwins();
    t_softrst();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule